// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Sequencer

This block is a compact 16-bit processor core whose control unit walks each instruction through an explicit chain of register transfers. The transfers use the program counter, a memory address register, a memory buffer register, an instruction register and a scratch register. The scratch register holds a data word while the buffer register is reused. The core also has eight data registers and eight address registers. Each micro-step has a fixed cost in cycles: 1 for a plain transfer, 2 for decode, 2 for an adder step (PC increment, effective address or branch target), 5 for multiply or divide, and 10 for a memory access. Every instruction therefore has a total that can be predicted exactly.

The core talks to one word-wide memory port using byte addresses. Instruction and data words sit at even addresses. Each access is a one-cycle request, and the memory answers with a ready strobe in the tenth cycle of the access. A free-running cycle counter and a one-cycle marker at the start of each instruction let an observer check per-instruction timing from outside. The core provides absolute loads and stores, a memory-to-memory copy with base-plus-displacement addressing on both sides, destructive register add, multiply and divide, a signed greater-than branch, and a halt.

Top module: `mcs_core`

## Requirements
- R1: Every instruction starts with the same 16-cycle fetch: address register from PC (1), read (10), instruction register from buffer (1), decode (2), PC += 2 (2). `instr_start` is high in the first fetch cycle, and the first instruction, at address 0, starts in the first cycle after reset.
- R2: Each memory access raises `mem_req` for exactly one cycle, with `mem_addr` taken from the address register. The access finishes on the edge where `mem_ready` is seen. With a memory that answers in the tenth cycle, an access costs 10 cycles.
- R3: The load word `0x3038 | (n<<9)` loads data register n, and `0x3078 | (n<<9)` loads address register n. Either one is followed by an absolute address word, loads the word at that address, leaves PC at the opcode address + 4, and takes 41 cycles.
- R4: The store word `0x3E00 | n` is followed by an absolute address word. It writes data register n to that address, leaves PC at the opcode address + 4, and takes 41 cycles.
- R5: The copy word `0x3168 | (d<<9) | s` is followed by a source displacement word and then a destination displacement word. It reads the word at address register s + source displacement and writes it to address register d + destination displacement. PC ends at the opcode address + 6, and the copy takes 68 cycles.
- R6: The add word `0xD000 | (j<<9) | i` sets Dj = Di + Dj (modulo 2^16) in 18 cycles.
- R7: The multiply word `0xC000 | (j<<9) | i` sets Dj to the low 16 bits of the unsigned product Di * Dj in 21 cycles.
- R8: The divide word `0x8000 | (j<<9) | i` sets Dj = Dj / Di (unsigned, remainder dropped) in 21 cycles. If Di is 0, Dj and the flags stay unchanged and the sticky `div_err` output rises.
- R9: Add, multiply, a successful divide and a data-register load set N = result bit 15 and Z = (result == 0). V is signed overflow for add, upper product half nonzero for multiply, and 0 for divide and load. Other instructions leave the flags unchanged.
- R10: The branch word `0x6E00` is followed by a displacement word. The branch is taken when Z = 0 and N = V. A taken branch sets PC = opcode address + 2 + displacement (modulo 2^16) in 29 cycles. A branch not taken sets PC = opcode address + 4 in 18 cycles.
- R11: Any other opcode word (such as `0xFFFF`) halts the core. `done` rises 16 cycles after that instruction starts, stays high, and no further memory request follows.
- R12: While reset is asserted, `done`, `div_err`, `mem_req` and `cycle_cnt` are 0. After reset, `cycle_cnt` increases by one every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Access is a write when high |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completion strobe |
| instr_start | output | 1 | High in the first cycle of each instruction |
| cycle_cnt | output | 32 | Free-running cycle counter |
| done | output | 1 | Core has halted |
| div_err | output | 1 | Sticky divide-by-zero indicator |

## Verification
The hardest situations to reach from the ports are the flag-dependent paths. One is a branch taken only because signed overflow made N equal V. Another is a divide by zero whose destination must survive unchanged. Neither can be seen directly, because registers are visible only through stores. The stimulus program first builds an add that overflows into the sign bit and then branches past a marker store. Next it loads a zero divisor, divides by it, and stores the untouched destination. Finally it branches on the leftover Z flag so that the not-taken path is timed. A behavioural instruction model in the bench predicts every instruction start cycle and every write. The bench compares these against the ports on every clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int WORD_W = 16;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);

    typedef enum logic [3:0] {
        OP_LDD, OP_LDA, OP_ST, OP_MOVM,
        OP_ADD, OP_MUL, OP_DIV, OP_BGT, OP_HALT
    } op_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_MUL, ALU_DIV
    } alu_op_e;

    typedef enum logic [4:0] {
        S_F_MAR, S_F_RD, S_F_IR, S_DEC, S_F_PC,
        S_X_MAR, S_X_RD,
        S_L_MAR, S_L_RD, S_L_WB,
        S_S_MBR, S_S_WR,
        S_M_EA, S_M_RD, S_M_WR, S_M_MBR,
        S_PC2, S_B_ADD,
        S_EX_ADD, S_EX_MUL, S_EX_DIV,
        S_HALT
    } step_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
    } flags_t;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rx;
        logic [RIDX_W-1:0] ry;
    } dec_t;

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
    import mcs_pkg::*;
(
    input  logic [WORD_W-1:0] ir,
    output dec_t              dec
);

    always_comb begin
        dec.rx = ir[11:9];
        dec.ry = ir[2:0];
        dec.op = OP_HALT;
        if (ir == 16'h6E00) begin
            dec.op = OP_BGT;
        end else if (ir[15:12] == 4'h3) begin
            if (ir[8:0] == 9'h038)              dec.op = OP_LDD;
            else if (ir[8:0] == 9'h078)         dec.op = OP_LDA;
            else if (ir[11:3] == 9'h1C0)        dec.op = OP_ST;
            else if (ir[8:3] == 6'b101101)      dec.op = OP_MOVM;
        end else if (ir[8:3] == 6'b000000) begin
            case (ir[15:12])
                4'hD:    dec.op = OP_ADD;
                4'hC:    dec.op = OP_MUL;
                4'h8:    dec.op = OP_DIV;
                default: dec.op = OP_HALT;
            endcase
        end
    end

endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
    import mcs_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] dst,
    output logic [W-1:0] res,
    output flags_t       fl,
    output logic         div_zero
);

    logic [2*W-1:0] prod;
    logic [W-1:0]   sum;

    always_comb begin
        sum      = src + dst;
        prod     = {{W{1'b0}}, src} * {{W{1'b0}}, dst};
        div_zero = (src == '0);
        fl.v     = 1'b0;
        case (op)
            ALU_ADD: begin
                res  = sum;
                fl.v = (src[W-1] == dst[W-1]) && (sum[W-1] != src[W-1]);
            end
            ALU_MUL: begin
                res  = prod[W-1:0];
                fl.v = |prod[2*W-1:W];
            end
            default: begin
                res  = div_zero ? dst : (dst / src);
            end
        endcase
        fl.n = res[W-1];
        fl.z = (res == '0);
    end

endmodule

// File: rtl/mcs_regbank.sv
module mcs_regbank #(
    parameter int W        = 16,
    parameter int N        = 8,
    parameter int RD_PORTS = 2,
    localparam int IDX_W   = $clog2(N)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                waddr,
    input  logic [W-1:0]                    wdata,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]  raddr,
    output logic [RD_PORTS-1:0][W-1:0]      rdata
);

    logic [N-1:0][W-1:0] regs_q;
    logic [N-1:0][W-1:0] regs_d;

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_comb begin
            regs_d[g] = (we && (waddr == IDX_W'(g))) ? wdata : regs_q[g];
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = regs_q[raddr[p]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/mcs_core.sv
module mcs_core
    import mcs_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int STEP_W    = 4,
    parameter int COST_XFER = 1,
    parameter int COST_DEC  = 2,
    parameter int COST_ADD  = 2,
    parameter int COST_MUL  = 5,
    parameter int COST_DIV  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              instr_start,
    output logic [CNT_W-1:0]  cycle_cnt,
    output logic              done,
    output logic              div_err
);

    localparam logic [STEP_W-1:0] LAST_XFER = STEP_W'(COST_XFER - 1);
    localparam logic [STEP_W-1:0] LAST_DEC  = STEP_W'(COST_DEC - 1);
    localparam logic [STEP_W-1:0] LAST_ADD  = STEP_W'(COST_ADD - 1);
    localparam logic [STEP_W-1:0] LAST_MUL  = STEP_W'(COST_MUL - 1);
    localparam logic [STEP_W-1:0] LAST_DIV  = STEP_W'(COST_DIV - 1);
    localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(2);

    typedef struct packed {
        step_e              step;
        logic [STEP_W-1:0]  cnt;
        logic               phase;
        logic [WORD_W-1:0]  pc;
        logic [WORD_W-1:0]  mar;
        logic [WORD_W-1:0]  mbr;
        logic [WORD_W-1:0]  ir;
        logic [WORD_W-1:0]  wr;
        flags_t             fl;
        logic               err;
        logic               done;
        logic [CNT_W-1:0]   cyc;
    } state_t;

    state_t s_q, s_d;

    dec_t                         dec;
    alu_op_e                      alu_op;
    logic [WORD_W-1:0]            alu_res;
    flags_t                       alu_fl;
    logic                         alu_div0;
    logic [1:0][RIDX_W-1:0]       d_raddr;
    logic [1:0][WORD_W-1:0]       d_rdata;
    logic [0:0][RIDX_W-1:0]       a_raddr;
    logic [0:0][WORD_W-1:0]       a_rdata;
    logic                         d_we, a_we;
    logic [WORD_W-1:0]            d_wdata, a_wdata;
    logic                         mem_step;
    logic                         step_end;
    logic [STEP_W-1:0]            last_cnt;
    logic                         gt;

    mcs_decode u_dec (
        .ir  (s_q.ir),
        .dec (dec)
    );

    always_comb begin
        case (dec.op)
            OP_MUL:  alu_op = ALU_MUL;
            OP_DIV:  alu_op = ALU_DIV;
            default: alu_op = ALU_ADD;
        endcase
    end

    mcs_alu #(.W(WORD_W)) u_alu (
        .op       (alu_op),
        .src      (d_rdata[0]),
        .dst      (d_rdata[1]),
        .res      (alu_res),
        .fl       (alu_fl),
        .div_zero (alu_div0)
    );

    assign d_raddr[0] = dec.ry;
    assign d_raddr[1] = dec.rx;
    assign a_raddr[0] = s_q.phase ? dec.rx : dec.ry;

    mcs_regbank #(.W(WORD_W), .N(NREG), .RD_PORTS(2)) u_dregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (d_we),
        .waddr (dec.rx),
        .wdata (d_wdata),
        .raddr (d_raddr),
        .rdata (d_rdata)
    );

    mcs_regbank #(.W(WORD_W), .N(NREG), .RD_PORTS(1)) u_aregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (a_we),
        .waddr (dec.rx),
        .wdata (a_wdata),
        .raddr (a_raddr),
        .rdata (a_rdata)
    );

    always_comb begin
        case (s_q.step)
            S_DEC:                           last_cnt = LAST_DEC;
            S_F_PC, S_PC2, S_M_EA,
            S_B_ADD, S_EX_ADD:               last_cnt = LAST_ADD;
            S_EX_MUL:                        last_cnt = LAST_MUL;
            S_EX_DIV:                        last_cnt = LAST_DIV;
            default:                         last_cnt = LAST_XFER;
        endcase
        mem_step = (s_q.step == S_F_RD) || (s_q.step == S_X_RD) ||
                   (s_q.step == S_L_RD) || (s_q.step == S_M_RD) ||
                   (s_q.step == S_S_WR);
        step_end = mem_step ? (mem_ready && (s_q.cnt != '0))
                            : (s_q.cnt == last_cnt);
        gt = !s_q.fl.z && (s_q.fl.n == s_q.fl.v);
    end

    always_comb begin
        s_d     = s_q;
        s_d.cyc = s_q.cyc + 1'b1;
        d_we    = 1'b0;
        a_we    = 1'b0;
        d_wdata = s_q.mbr;
        a_wdata = s_q.mbr;
        if (!step_end) begin
            if (s_q.cnt != '1) s_d.cnt = s_q.cnt + 1'b1;
        end else begin
            s_d.cnt = '0;
            case (s_q.step)
                S_F_MAR: begin
                    s_d.mar  = s_q.pc;
                    s_d.step = S_F_RD;
                end
                S_F_RD: begin
                    s_d.mbr  = mem_rdata;
                    s_d.step = S_F_IR;
                end
                S_F_IR: begin
                    s_d.ir   = s_q.mbr;
                    s_d.step = S_DEC;
                end
                S_DEC: s_d.step = S_F_PC;
                S_F_PC: begin
                    s_d.pc    = s_q.pc + WORD_BYTES;
                    s_d.phase = 1'b0;
                    case (dec.op)
                        OP_LDD, OP_LDA, OP_ST, OP_MOVM: s_d.step = S_X_MAR;
                        OP_ADD:  s_d.step = S_EX_ADD;
                        OP_MUL:  s_d.step = S_EX_MUL;
                        OP_DIV:  s_d.step = S_EX_DIV;
                        OP_BGT:  s_d.step = gt ? S_X_MAR : S_PC2;
                        default: begin
                            s_d.step = S_HALT;
                            s_d.done = 1'b1;
                        end
                    endcase
                end
                S_X_MAR: begin
                    s_d.mar  = s_q.pc;
                    s_d.step = S_X_RD;
                end
                S_X_RD: begin
                    s_d.mbr = mem_rdata;
                    case (dec.op)
                        OP_MOVM: s_d.step = S_M_EA;
                        OP_BGT:  s_d.step = S_B_ADD;
                        default: s_d.step = S_L_MAR;
                    endcase
                end
                S_L_MAR: begin
                    s_d.mar  = s_q.mbr;
                    s_d.step = (dec.op == OP_ST) ? S_S_MBR : S_L_RD;
                end
                S_L_RD: begin
                    s_d.mbr  = mem_rdata;
                    s_d.step = S_L_WB;
                end
                S_L_WB: begin
                    if (dec.op == OP_LDA) begin
                        a_we = 1'b1;
                    end else begin
                        d_we     = 1'b1;
                        s_d.fl.n = s_q.mbr[WORD_W-1];
                        s_d.fl.z = (s_q.mbr == '0);
                        s_d.fl.v = 1'b0;
                    end
                    s_d.step = S_PC2;
                end
                S_S_MBR: begin
                    s_d.mbr  = d_rdata[0];
                    s_d.step = S_S_WR;
                end
                S_S_WR: s_d.step = S_PC2;
                S_M_EA: begin
                    s_d.mar  = a_rdata[0] + s_q.mbr;
                    s_d.step = s_q.phase ? S_M_MBR : S_M_RD;
                end
                S_M_RD: begin
                    s_d.mbr  = mem_rdata;
                    s_d.step = S_M_WR;
                end
                S_M_WR: begin
                    s_d.wr   = s_q.mbr;
                    s_d.step = S_PC2;
                end
                S_M_MBR: begin
                    s_d.mbr  = s_q.wr;
                    s_d.step = S_S_WR;
                end
                S_PC2: begin
                    s_d.pc = s_q.pc + WORD_BYTES;
                    if ((dec.op == OP_MOVM) && !s_q.phase) begin
                        s_d.phase = 1'b1;
                        s_d.step  = S_X_MAR;
                    end else begin
                        s_d.step  = S_F_MAR;
                    end
                end
                S_B_ADD: begin
                    s_d.pc   = s_q.pc + s_q.mbr;
                    s_d.step = S_F_MAR;
                end
                S_EX_ADD, S_EX_MUL, S_EX_DIV: begin
                    d_wdata = alu_res;
                    if ((s_q.step == S_EX_DIV) && alu_div0) begin
                        s_d.err = 1'b1;
                    end else begin
                        d_we   = 1'b1;
                        s_d.fl = alu_fl;
                    end
                    s_d.step = S_F_MAR;
                end
                default: s_d.step = S_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.step <= S_F_MAR;
        end else begin
            s_q      <= s_d;
        end
    end

    assign mem_req     = mem_step && (s_q.cnt == '0);
    assign mem_we      = (s_q.step == S_S_WR);
    assign mem_addr    = s_q.mar;
    assign mem_wdata   = s_q.mbr;
    assign instr_start = (s_q.step == S_F_MAR);
    assign cycle_cnt   = s_q.cyc;
    assign done        = s_q.done;
    assign div_err     = s_q.err;

    // R2: a request never stretches over two cycles
    assert_req_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R2: the memory only answers while an access is in flight
    assert_ready_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> mem_step);

    // R1: an instruction fetch reads from the address PC held one cycle before
    assert_fetch_from_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (s_q.step == S_F_RD)) |-> (mem_addr == $past(s_q.pc)));

    // R11: once halted the core stays halted and quiet
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !mem_req));

    // R8: the divide error indication never clears
    assert_div_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);

    // R12: the cycle counter advances by one each clock
    assert_cycle_advance_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(cycle_cnt) |=> (cycle_cnt != $past(cycle_cnt)));

endmodule

// File: tb/mcs_core_tb_top.sv
module mcs_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        instr_start;
    logic [31:0] cycle_cnt;
    logic        done, div_err;

    always #10 clk = ~clk;

    mcs_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .instr_start (instr_start),
        .cycle_cnt   (cycle_cnt),
        .done        (done),
        .div_err     (div_err)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    logic [15:0] mem [256];
    logic [15:0] mm  [256];

    // memory: answers in the tenth cycle of an access
    int          lat = 0;
    logic [15:0] rd_hold = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            lat = 0;
            mem_ready = 1'b0;
        end else begin
            mem_ready = 1'b0;
            if (lat != 0) begin
                if (lat == 9) begin
                    mem_ready = 1'b1;
                    mem_rdata = rd_hold;
                    lat = 0;
                end else begin
                    lat++;
                end
            end
            if (mem_req) begin
                lat = 1;
                if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
                else        rd_hold = mem[mem_addr[8:1]];
            end
        end
    end

    // behavioural instruction model
    longint      starts[$];
    string       stags[$];
    int          wq_addr[$];
    int          wq_data[$];
    string       wq_tag[$];
    longint      done_cyc = -1;
    bit          exp_err = 0;

    task automatic run_model();
        logic [15:0] md [8];
        logic [15:0] ma [8];
        bit fn = 0, fz = 0, fv = 0;
        logic [15:0] pc = '0;
        longint cyc = 0;
        string tag = "R1";
        for (int k = 0; k < 8; k++) begin md[k] = '0; ma[k] = '0; end
        for (int n = 0; n < 200; n++) begin
            logic [15:0] ir, ext, ext2, r, ea;
            logic [31:0] p;
            int i, j;
            starts.push_back(cyc);
            stags.push_back(tag);
            ir = mm[pc[8:1]];
            i = int'(ir[2:0]);
            j = int'(ir[11:9]);
            cyc += 16;
            if (ir == 16'h6E00) begin
                if (!fz && (fn == fv)) begin
                    ext = mm[pc[8:1] + 8'd1];
                    pc = pc + 16'd2 + ext;
                    cyc += 13;
                end else begin
                    pc = pc + 16'd4;
                    cyc += 2;
                end
                tag = "R10/R9";
            end else if (ir[15:12] == 4'h3 && (ir[8:0] == 9'h038 || ir[8:0] == 9'h078)) begin
                ext = mm[pc[8:1] + 8'd1];
                r = mm[ext[8:1]];
                if (ir[6]) ma[j] = r;
                else begin md[j] = r; fn = r[15]; fz = (r == 0); fv = 0; end
                pc = pc + 16'd4;
                cyc += 25;
                tag = "R3";
            end else if (ir[15:12] == 4'h3 && ir[11:3] == 9'h1C0) begin
                ext = mm[pc[8:1] + 8'd1];
                mm[ext[8:1]] = md[i];
                wq_addr.push_back(int'(ext)); wq_data.push_back(int'(md[i])); wq_tag.push_back("R4");
                pc = pc + 16'd4;
                cyc += 25;
                tag = "R4";
            end else if (ir[15:12] == 4'h3 && ir[8:3] == 6'b101101) begin
                ext  = mm[pc[8:1] + 8'd1];
                ext2 = mm[pc[8:1] + 8'd2];
                r  = mm[(ma[i] + ext) >> 1];
                ea = ma[j] + ext2;
                mm[ea[8:1]] = r;
                wq_addr.push_back(int'(ea)); wq_data.push_back(int'(r)); wq_tag.push_back("R5");
                pc = pc + 16'd6;
                cyc += 52;
                tag = "R5";
            end else if (ir[8:3] == 6'd0 && ir[15:12] == 4'hD) begin
                r = md[i] + md[j];
                fv = (md[i][15] == md[j][15]) && (r[15] != md[i][15]);
                md[j] = r; fn = r[15]; fz = (r == 0);
                pc = pc + 16'd2; cyc += 2; tag = "R6";
            end else if (ir[8:3] == 6'd0 && ir[15:12] == 4'hC) begin
                p = {16'd0, md[i]} * {16'd0, md[j]};
                md[j] = p[15:0]; fv = (p[31:16] != 0); fn = p[15]; fz = (p[15:0] == 0);
                pc = pc + 16'd2; cyc += 5; tag = "R7";
            end else if (ir[8:3] == 6'd0 && ir[15:12] == 4'h8) begin
                if (md[i] == 0) exp_err = 1;
                else begin
                    md[j] = md[j] / md[i]; fv = 0; fn = md[j][15]; fz = (md[j] == 0);
                end
                pc = pc + 16'd2; cyc += 5; tag = "R8";
            end else begin
                done_cyc = cyc;
                break;
            end
        end
    endtask

    // per-clock comparison against the model
    bit     run = 0;
    longint tb_cyc = 0;
    bit     prev_req = 0;
    bit     prev_done = 0;
    always @(negedge clk) begin
        if (run) begin
            check(cycle_cnt == 32'(tb_cyc), "R12 counter", cycle_cnt, tb_cyc);
            if (instr_start && starts.size() > 0) begin
                longint e;
                string  t;
                e = starts.pop_front();
                t = stags.pop_front();
                check(longint'(cycle_cnt) == e, {t, " instruction timing"}, cycle_cnt, e);
            end
            if (mem_req) begin
                check(!prev_req && !mem_addr[0], "R2 request shape", mem_addr, 0);
                check(!done, "R11 no access after halt", mem_req, 0);
            end
            if (mem_req && mem_we) begin
                if (wq_addr.size() > 0) begin
                    int a, d;
                    string t;
                    a = wq_addr.pop_front(); d = wq_data.pop_front(); t = wq_tag.pop_front();
                    check(mem_addr == 16'(a), {t, " write address"}, mem_addr, a);
                    check(mem_wdata == 16'(d), {t, " write data"}, mem_wdata, d);
                end else begin
                    check(1'b0, "R4 unexpected write", mem_addr, 0);
                end
            end
            if (done && !prev_done)
                check(longint'(cycle_cnt) == done_cyc, "R11 halt timing", cycle_cnt, done_cyc);
            prev_req  = mem_req;
            prev_done = done;
            tb_cyc++;
        end
    end

    task automatic put(input int addr, input logic [15:0] w);
        mem[addr >> 1] = w;
    endtask

    initial begin
        bit timeout = 0;
        for (int k = 0; k < 256; k++) mem[k] = '0;
        put('h00, 16'h3238); put('h02, 16'h0100);
        put('h04, 16'h3438); put('h06, 16'h0102);
        put('h08, 16'h3038); put('h0A, 16'h0104);
        put('h0C, 16'hD401);
        put('h0E, 16'hC401);
        put('h10, 16'h8401);
        put('h12, 16'h3E02); put('h14, 16'h0110);
        put('h16, 16'hD001);
        put('h18, 16'h6E00); put('h1A, 16'h0006);
        put('h1C, 16'h3E00); put('h1E, 16'h0118);
        put('h20, 16'h3638); put('h22, 16'h0106);
        put('h24, 16'h8203);
        put('h26, 16'h6E00); put('h28, 16'h0010);
        put('h2A, 16'h3E01); put('h2C, 16'h0112);
        put('h2E, 16'h3678); put('h30, 16'h0120);
        put('h32, 16'h3278); put('h34, 16'h0122);
        put('h36, 16'h336B); put('h38, 16'h0016); put('h3A, 16'h0018);
        put('h3C, 16'h3838); put('h3E, 16'h0108);
        put('h40, 16'hC804);
        put('h42, 16'h3E04); put('h44, 16'h011A);
        put('h46, 16'h6E00); put('h48, 16'h0004);
        put('h4A, 16'hFFFF);
        put('h100, 16'h0007); put('h102, 16'h0005); put('h104, 16'h7FFF);
        put('h106, 16'h0000); put('h108, 16'h1000); put('h116, 16'hBEEF);
        put('h11A, 16'h5555);
        put('h120, 16'h0100); put('h122, 16'h0140);
        for (int k = 0; k < 256; k++) mm[k] = mem[k];
        run_model();

        repeat (3) @(negedge clk);
        check(done == 0 && div_err == 0, "R12 reset outputs", {done, div_err}, 0);
        check(mem_req == 0 && cycle_cnt == 0, "R12 reset request/counter", cycle_cnt, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);
        check(instr_start == 1'b1, "R1 first start", instr_start, 1);

        fork
            begin
                wait (done);
                repeat (40) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;

        if (timeout) check(1'b0, "R11 watchdog expired", 0, 1);
        check(starts.size() == 0, "R1 all instructions started", starts.size(), 0);
        check(wq_addr.size() == 0, "R4 all writes seen", wq_addr.size(), 0);
        check(div_err == exp_err, "R8 divide error flag", div_err, exp_err);
        check(mem['h110 >> 1] == 16'd12, "R6 R7 R8 arithmetic result", mem['h110 >> 1], 12);
        check(mem['h112 >> 1] == 16'd7, "R8 zero divisor keeps destination", mem['h112 >> 1], 7);
        check(mem['h118 >> 1] == 16'd0, "R10 R9 taken branch skips store", mem['h118 >> 1], 0);
        check(mem['h158 >> 1] == 16'hBEEF, "R5 copied word", mem['h158 >> 1], 16'hBEEF);
        check(mem['h11A >> 1] == 16'h0000, "R7 R9 multiply low half", mem['h11A >> 1], 0);
        for (int k = 0; k < 256; k++)
            if (mem[k] != mm[k]) check(1'b0, "R3 memory image", mem[k], mm[k]);
        check(done == 1'b1, "R11 done held", done, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule